// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register-side front end of a high-precision event timer. It decodes a 1 KiB register window. Reads and writes may be 1, 2, 4 or 8 bytes wide, and each access is applied to a 64-bit register through byte-lane extraction on reads and byte-lane merging on writes. The block holds the capability word, the general control register and the free-running 64-bit main counter. It presents a status vector that arrives from outside. Accesses to the timer-channel registers are forwarded to per-channel blocks over a plain select/register-code/data strobe. The comparators and the interrupt logic sit in those channel blocks and are not part of this design.

The request side uses a valid-only handshake and has no back-pressure. A request is taken on every cycle in which `req_valid` is high. Each accepted read returns exactly one `rsp_valid` pulse one cycle later, carrying the data. The response path has no ready signal, so the consumer must take the data in the cycle it appears. Writes return no response.

The main counter advances on cycles in which `tick_en` is high, and only while the general enable bit is set. When that bit is cleared the counter freezes, and software can load it with any value. A load made while counting is running pulses `cnt_rearm` so that the channel blocks re-arm against the new count.

Top module: `evt_tmr_regif`

## Requirements
- R1: After reset, the 64-bit word at offset 0x000 reads 0x00F42400_8086A201 (16,000,000 fs per tick in the upper half; 64-bit counter, three timers and legacy-capable in the lower half), the general control word at 0x010 reads 0, and the counter at 0x0F0 reads 0.
- R2: Every read request produces `rsp_valid` high in the following cycle with the data on `rsp_data`. Write requests never produce `rsp_valid`.
- R3: A read of length L at address A returns the 64-bit register at A rounded down to 8, shifted right by 8·(A mod 8) bits and masked to the low 8·L bits.
- R4: A write of length L at address A replaces only bytes A mod 8 through A mod 8 + L − 1 of the target 64-bit register and keeps its other bytes.
- R5: An access is rejected when A is not a multiple of L or when L > 8. A rejected read returns all ones, and a rejected write changes no register and raises no channel strobe.
- R6: In the general control word, only bits 1:0 are stored. Bit 0 drives `gen_enable` and bit 1 drives `legacy_route`. All other bits read as zero.
- R7: While `gen_enable` is 1, the main counter increases by one on each cycle with `tick_en` high. While it is 0, the counter holds its value.
- R8: A write to the counter word loads the merged value on the next edge, and a load takes priority over a tick in the same cycle. If `gen_enable` was 1 when the write was made, `cnt_rearm` is high for exactly the following cycle.
- R9: For n < 3, channel n has its register codes at 0x100+0x20·n (code 0, configuration), 0x108+0x20·n (code 1, comparator) and 0x110+0x20·n (code 2, route). An accepted write there raises `ch_wr_stb` in the same cycle, with one-hot `ch_sel` bit n, `ch_reg` set to the code and `ch_wdata` set to the merged 64-bit value. A read returns the selected lanes of `ch_rdata` slice n, which the channel drives for the current `ch_reg`.
- R10: Unmapped offsets read as zero and ignore writes. The word at 0x020 reads `status_in` zero-extended and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter tick qualifier |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset in the window |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data, right-aligned |
| gen_enable | output | 1 | General enable bit |
| legacy_route | output | 1 | Legacy routing select bit |
| main_count | output | 64 | Main counter value |
| cnt_rearm | output | 1 | Counter reloaded while running |
| status_in | input | 3 | Per-channel status from the channel blocks |
| ch_wr_stb | output | 1 | Channel register write strobe |
| ch_sel | output | 3 | One-hot channel select for writes |
| ch_reg | output | 2 | Channel register code |
| ch_wdata | output | 64 | Merged channel write value |
| ch_rdata | input | 192 | Per-channel current register value, 64 bits each |

## Verification
The hardest situations to reach are the timing interactions around the counter. These include a sub-word load that lands while the counter is running, a load on the same edge as a tick, and a misaligned write aimed at the control word, which must not stop or start the counter. The stimulus drives `tick_en` at a fixed one-in-four ratio and issues a long stream of seeded random accesses, aligned and occasionally misaligned, over every mapped and several unmapped offsets. The bench's own model tracks the counter, the control bits and the channel registers edge by edge. Directed sequences cover freezing and resuming, oversize lengths, and writes to the read-only words.

// File: rtl/evt_regif_pkg.sv
package evt_regif_pkg;
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CAP,
    TGT_CTRL,
    TGT_STAT,
    TGT_CNT,
    TGT_CHAN
  } tgt_e;

  localparam logic [31:0] TICK_FS = 32'd16_000_000;
endpackage

// File: rtl/evt_regif_decode.sv
module evt_regif_decode
  import evt_regif_pkg::*;
#(
  parameter int AW  = 10,
  parameter int NCH = 3,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0]  addr,
  input  logic [3:0]     len,
  output tgt_e           tgt,
  output logic [CHW-1:0] ch_idx,
  output logic [1:0]     ch_code,
  output logic           reject
);
  localparam int WW = AW - 3;
  localparam logic [WW-1:0] W_CAP  = WW'(0);
  localparam logic [WW-1:0] W_CTRL = WW'(2);
  localparam logic [WW-1:0] W_STAT = WW'(4);
  localparam logic [WW-1:0] W_CNT  = WW'(30);
  localparam logic [WW-1:0] W_CHB  = WW'(32);

  logic [WW-1:0] word;
  logic [WW-1:0] relw;
  logic [3:0]    lmask;

  assign word    = addr[AW-1:3];
  assign relw    = word - W_CHB;
  assign lmask   = len - 4'd1;
  assign reject  = (len > 4'd8) || ((addr[3:0] & lmask) != 4'd0);
  assign ch_idx  = relw[2 +: CHW];
  assign ch_code = relw[1:0];

  always_comb begin
    tgt = TGT_NONE;
    if (word == W_CAP)       tgt = TGT_CAP;
    else if (word == W_CTRL) tgt = TGT_CTRL;
    else if (word == W_STAT) tgt = TGT_STAT;
    else if (word == W_CNT)  tgt = TGT_CNT;
    else if (word >= W_CHB && int'(relw[WW-1:2]) < NCH && relw[1:0] != 2'd3)
      tgt = TGT_CHAN;
  end
endmodule

// File: rtl/evt_regif_lanes.sv
module evt_regif_lanes (
  input  logic [2:0]  off,
  input  logic [3:0]  len,
  input  logic [63:0] cur,
  input  logic [63:0] wdata,
  output logic [63:0] rd_val,
  output logic [63:0] wr_val
);
  logic [63:0] down;
  logic [63:0] up;

  assign down = cur >> {off, 3'b000};
  assign up   = wdata << {off, 3'b000};

  always_comb begin
    for (int b = 0; b < 8; b++) begin
      rd_val[b*8 +: 8] = (b < int'(len)) ? down[b*8 +: 8] : 8'h00;
      wr_val[b*8 +: 8] = (b >= int'(off) && b < int'(off) + int'(len))
                         ? up[b*8 +: 8] : cur[b*8 +: 8];
    end
  end
endmodule

// File: rtl/evt_regif_counter.sv
module evt_regif_counter #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (load)        count <= load_val;
    else if (run && tick) count <= count + CW'(1);
  end
endmodule

// File: rtl/evt_tmr_regif.sv
module evt_tmr_regif
  import evt_regif_pkg::*;
#(
  parameter int AW  = 10,
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [3:0]        req_len,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              gen_enable,
  output logic              legacy_route,
  output logic [63:0]       main_count,
  output logic              cnt_rearm,
  input  logic [NCH-1:0]    status_in,
  output logic              ch_wr_stb,
  output logic [NCH-1:0]    ch_sel,
  output logic [1:0]        ch_reg,
  output logic [63:0]       ch_wdata,
  input  logic [NCH*64-1:0] ch_rdata
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [63:0] CAP_WORD =
    {TICK_FS, 16'h8086, 1'b1, 1'b0, 1'b1, 5'(NCH - 1), 8'h01};

  tgt_e           tgt;
  logic [CHW-1:0] ch_idx;
  logic           reject;
  logic [63:0]    cur_val, rd_val, wr_val;
  logic [1:0]     ctrl_q;
  logic           wr_ok, cnt_load;

  evt_regif_decode #(.AW(AW), .NCH(NCH)) u_dec (
    .addr(req_addr), .len(req_len), .tgt(tgt),
    .ch_idx(ch_idx), .ch_code(ch_reg), .reject(reject)
  );

  always_comb begin
    case (tgt)
      TGT_CAP:  cur_val = CAP_WORD;
      TGT_CTRL: cur_val = {62'd0, ctrl_q};
      TGT_STAT: cur_val = 64'(status_in);
      TGT_CNT:  cur_val = main_count;
      TGT_CHAN: cur_val = ch_rdata[ch_idx*64 +: 64];
      default:  cur_val = 64'd0;
    endcase
  end

  evt_regif_lanes u_lanes (
    .off(req_addr[2:0]), .len(req_len), .cur(cur_val),
    .wdata(req_wdata), .rd_val(rd_val), .wr_val(wr_val)
  );

  assign wr_ok     = req_valid && req_write && !reject;
  assign cnt_load  = wr_ok && (tgt == TGT_CNT);
  assign ch_wr_stb = wr_ok && (tgt == TGT_CHAN);
  assign ch_wdata  = wr_val;

  always_comb begin
    ch_sel = '0;
    if (ch_wr_stb) ch_sel[ch_idx] = 1'b1;
  end

  evt_regif_counter #(.CW(64)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[0]), .tick(tick_en),
    .load(cnt_load), .load_val(wr_val), .count(main_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= 2'b00;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      cnt_rearm <= 1'b0;
    end else begin
      if (wr_ok && tgt == TGT_CTRL) ctrl_q <= wr_val[1:0];
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_data <= reject ? '1 : rd_val;
      cnt_rearm <= cnt_load && ctrl_q[0];
    end
  end

  assign gen_enable   = ctrl_q[0];
  assign legacy_route = ctrl_q[1];
endmodule

// File: rtl/evt_tmr_regif_chk.sv
module evt_tmr_regif_chk #(
  parameter int AW  = 10,
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick_en,
  input logic           req_valid,
  input logic           req_write,
  input logic [3:0]     req_len,
  input logic           rsp_valid,
  input logic [63:0]    rsp_data,
  input logic           gen_enable,
  input logic [63:0]    main_count,
  input logic           cnt_rearm,
  input logic           ch_wr_stb,
  input logic [NCH-1:0] ch_sel
);
  // R2
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R2
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  // R5
  oversize_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_len > 4'd8) |=> (rsp_data == '1));
  // R7
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_enable && !req_valid) |=> $stable(main_count));
  // R7
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_enable && tick_en && !req_valid) |=> (main_count == $past(main_count) + 64'd1));
  // R8
  rearm_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rearm |-> $past(gen_enable));
  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr_stb |-> $onehot(ch_sel));
endmodule

bind evt_tmr_regif evt_tmr_regif_chk #(.AW(AW), .NCH(NCH)) chk_i (.*);

// File: tb/evt_tmr_regif_tb_top.sv
module evt_tmr_regif_tb_top;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [9:0] req_addr = '0;
  logic [3:0] req_len = 4'd8;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, gen_enable, legacy_route, cnt_rearm, ch_wr_stb;
  logic [63:0] rsp_data, main_count, ch_wdata;
  logic [NCH-1:0] status_in = 3'b101;
  logic [NCH-1:0] ch_sel;
  logic [1:0] ch_reg;
  logic [NCH*64-1:0] ch_rdata;

  always #2.5 clk = ~clk;

  evt_tmr_regif dut_i (.*);

  // channel blocks stand-in, driven by the DUT's strobe
  logic [63:0] ch_mem [NCH][3];
  always_comb begin
    for (int n = 0; n < NCH; n++)
      ch_rdata[n*64 +: 64] = (ch_reg == 2'd3) ? 64'd0 : ch_mem[n][ch_reg];
  end
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++) for (int r = 0; r < 3; r++) ch_mem[n][r] <= 64'd0;
    end else if (ch_wr_stb) begin
      for (int n = 0; n < NCH; n++) if (ch_sel[n] && ch_reg != 2'd3) ch_mem[n][ch_reg] <= ch_wdata;
    end
  end

  // tick at one in four cycles
  int div = 0;
  always @(negedge clk) begin
    div = (div + 1) % 4;
    tick_en = (div == 0);
  end

  // reference model
  logic [1:0]  m_ctrl;
  logic [63:0] m_cnt;
  logic [63:0] m_ch [NCH][3];
  localparam logic [63:0] CAP_EXP = 64'h00F42400_8086A201;

  function automatic bit f_bad(logic [9:0] a, logic [3:0] l);
    return (l > 8) || ((int'(a) % int'(l)) != 0);
  endfunction
  function automatic logic [63:0] f_mask(logic [3:0] l);
    return (l >= 8) ? '1 : ((64'd1 << (l * 8)) - 64'd1);
  endfunction
  function automatic logic [63:0] f_ext(logic [63:0] v, logic [2:0] o, logic [3:0] l);
    return (v >> (o * 8)) & f_mask(l);
  endfunction
  function automatic logic [63:0] f_merge(logic [63:0] v, logic [63:0] w, logic [2:0] o, logic [3:0] l);
    logic [63:0] m;
    m = f_mask(l) << (o * 8);
    return ((w << (o * 8)) & m) | (v & ~m);
  endfunction
  // kind: 0 none,1 cap,2 ctrl,3 stat,4 cnt,5 chan
  function automatic int f_kind(logic [9:0] a, output int n, output int r);
    int w;
    w = int'(a) / 8 * 8;
    n = 0; r = 0;
    if (w == 0) return 1;
    if (w == 'h10) return 2;
    if (w == 'h20) return 3;
    if (w == 'hF0) return 4;
    if (w >= 'h100 && w < 'h100 + 32 * NCH && (w % 32) < 24) begin
      n = (w - 'h100) / 32; r = (w % 32) / 8; return 5;
    end
    return 0;
  endfunction
  function automatic logic [63:0] f_cur(logic [9:0] a);
    int n, r, k;
    k = f_kind(a, n, r);
    case (k)
      1: return CAP_EXP;
      2: return {62'd0, m_ctrl};
      3: return 64'(status_in);
      4: return m_cnt;
      5: return m_ch[n][r];
      default: return 64'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl <= 0; m_cnt <= 0;
      for (int n = 0; n < NCH; n++) for (int r = 0; r < 3; r++) m_ch[n][r] <= 0;
    end else begin
      int n, r, k;
      logic [63:0] nv;
      if (m_ctrl[0] && tick_en) m_cnt <= m_cnt + 1;
      if (req_valid && req_write && !f_bad(req_addr, req_len)) begin
        k = f_kind(req_addr, n, r);
        nv = f_merge(f_cur(req_addr), req_wdata, req_addr[2:0], req_len);
        if (k == 2) m_ctrl <= nv[1:0];
        if (k == 4) m_cnt <= nv;
        if (k == 5) m_ch[n][r] <= nv;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic xfer(bit wr, logic [9:0] a, logic [3:0] l, logic [63:0] wd, string rq);
    logic [63:0] exp_rd;
    bit bad, exp_rearm;
    int n, r, k;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_len = l; req_wdata = wd;
    #0.1;
    bad = f_bad(a, l);
    k = f_kind(a, n, r);
    exp_rd = bad ? '1 : f_ext(f_cur(a), a[2:0], l);
    exp_rearm = wr && !bad && k == 4 && m_ctrl[0];
    if (wr) begin
      // R9 / R5 strobe and merged data
      check("R9 strobe", {63'd0, ch_wr_stb}, {63'd0, !bad && k == 5});
      if (!bad && k == 5) begin
        check("R9 sel", 64'(ch_sel), 64'(1 << n));
        check("R9 code", 64'(ch_reg), 64'(r));
        check("R4 ch merge", ch_wdata, f_merge(m_ch[n][r], wd, a[2:0], l));
      end
    end
    @(negedge clk);
    req_valid = 0;
    check("R2 rsp_valid", {63'd0, rsp_valid}, {63'd0, !wr});
    if (!wr) check({rq, " R3 read"}, rsp_data, exp_rd);
    else check("R8 rearm", {63'd0, cnt_rearm}, {63'd0, exp_rearm});
  endtask

  task automatic rd(logic [9:0] a, logic [3:0] l, string rq);
    xfer(0, a, l, 64'd0, rq);
  endtask
  task automatic wr(logic [9:0] a, logic [3:0] l, logic [63:0] d);
    xfer(1, a, l, d, "wr");
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    while (!done) begin
      @(posedge clk);
      if (n_chk > 0 && $time > 1_000_000_000) break;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] a;
    logic [3:0] l;
    logic [63:0] c0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(10'h000, 8, "R1 cap");
    rd(10'h010, 8, "R1 ctrl");
    rd(10'h0F0, 8, "R1 count");
    rd(10'h004, 4, "R1 R3 period half");
    rd(10'h002, 2, "R3 cap lane");
    // R6 control bits
    wr(10'h010, 8, 64'hFFFF_FFFF_FFFF_FFFE);
    @(negedge clk);
    check("R6 legacy", {63'd0, legacy_route}, 64'd1);
    check("R6 enable", {63'd0, gen_enable}, 64'd0);
    rd(10'h010, 8, "R6 ctrl mask");
    // R7 frozen
    wr(10'h0F0, 4, 64'h1234_5678);
    repeat (10) @(negedge clk);
    check("R7 hold", main_count, 64'h1234_5678);
    // R5 misaligned write ignored
    wr(10'h011, 2, 64'hFFFF);
    wr(10'h010, 2, 64'h0003);
    check("R5 ctrl kept", {63'd0, gen_enable}, 64'd1);
    wr(10'h012, 4, 64'hFFFF_FFFF);
    // R7 running
    c0 = m_cnt;
    repeat (20) @(negedge clk);
    check("R7 advance", main_count, m_cnt);
    check("R7 moved", {63'd0, main_count != c0}, 64'd1);
    // R8 running load with rearm
    wr(10'h0F4, 4, 64'hAAAA_0000);
    rd(10'h0F0, 8, "R8 load");
    // R5 bad lengths
    rd(10'h000, 4'd9, "R5 oversize");
    rd(10'h0F1, 2, "R5 misaligned");
    // R10 unmapped and status
    wr(10'h040, 8, '1);
    rd(10'h040, 8, "R10 unmapped");
    wr(10'h020, 8, '1);
    rd(10'h020, 8, "R10 status");
    rd(10'h118, 8, "R10 chan hole");
    // R9 channel
    wr(10'h148, 8, 64'h0102_0304_0506_0708);
    wr(10'h14C, 2, 64'hBEEF);
    rd(10'h148, 8, "R9 R4 chan cmp");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int pick;
      pick = $urandom_range(0, 15);
      case (pick)
        0: a = 10'h000; 1: a = 10'h010; 2: a = 10'h020; 3: a = 10'h0F0;
        4: a = 10'h100; 5: a = 10'h108; 6: a = 10'h110; 7: a = 10'h120;
        8: a = 10'h128; 9: a = 10'h130; 10: a = 10'h140; 11: a = 10'h148;
        12: a = 10'h150; 13: a = 10'h030; 14: a = 10'h3F8; default: a = 10'h0F0;
      endcase
      l = 4'(1 << $urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) a = a + 10'($urandom_range(0, 7));
      else a = a + (10'($urandom_range(0, 7)) & ~10'(l - 1) & 10'h7);
      if (a == 10'h010 && $urandom_range(0, 1) == 0) l = 8;
      xfer($urandom_range(0, 1) == 1, a, l, {$urandom, $urandom}, "rand");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule